// File: doc/BRIEF.md
# Two-Thread Switch-on-Event Controller

This block decides which of two hardware threads owns an in-order pipeline. It implements coarse-grain multithreading. One thread keeps the pipeline until a qualifying event arrives. The controller then drains the pipeline, waits out a fixed dead period and hands the pipeline to the other thread. Each thread drives its own event lines:

- a long-latency last-level cache miss;
- an invalidation in its speculative-load address table, as seen on spin-lock release;
- a software or power-management yield hint.

A programmable fairness timer adds a fourth trigger. It bounds how long one thread may hold the pipeline.

The core uses the outputs as follows. The active thread ID and a one-hot select choose the copy of the replicated per-thread state: register file, return stack and load table. The issue enable gates the front end. The flush output tells the pipeline to discard its in-flight work. A cause vector reports which triggers started the most recent switch.

Top module: `soe_thread_ctrl`

## Requirements
- R1: After reset, thread 0 is active, issue_en is 1, flush is 0, cause is 0 and thr_sel is 2'b01.
- R2: When the active thread raises a miss, invalidation or hint event in a cycle where issue_en is 1, issue_en is 0 and flush is 1 in the following cycle.
- R3: A switch holds issue_en at 0 for exactly 15 consecutive cycles (FLUSH_CYCLES + DELAY_CYCLES). In the next cycle issue_en is 1 and active_tid is the other thread.
- R4: Within the dead period, flush is 1 for the first 8 cycles (FLUSH_CYCLES) and 0 for the remaining 7 cycles (DELAY_CYCLES).
- R5: Events raised while a switch is in progress have no effect. The dead period keeps its length, no second switch follows, and cause keeps its value.
- R6: Events raised by the thread that does not own the pipeline cause no switch. issue_en stays 1 and active_tid is unchanged.
- R7: A thread that gains the pipeline gets exactly tmo_limit+1 issuing cycles when no other event occurs. The timeout trigger then starts a switch.
- R8: Triggers that are asserted in the same cycle produce a single switch. cause records every trigger present, with bit 0 = miss, bit 1 = invalidation, bit 2 = timeout and bit 3 = hint. cause holds this value until the next switch begins.
- R9: thr_sel is one-hot. Bit i is set exactly when thread i is active: 2'b01 for thread 0 and 2'b10 for thread 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tmo_limit | input | TMO_W | Fairness limit; a thread issues tmo_limit+1 cycles before a timeout switch |
| ev_miss | input | 2 | Per-thread last-level cache miss event |
| ev_inval | input | 2 | Per-thread load-table invalidation event |
| ev_hint | input | 2 | Per-thread software or power-management yield hint |
| active_tid | output | 1 | Thread that owns (or will next own) the pipeline state |
| issue_en | output | 1 | Issue permitted for the active thread |
| flush | output | 1 | Pipeline drain in progress |
| thr_sel | output | 2 | One-hot select of the replicated per-thread state |
| cause | output | 4 | Triggers that started the last switch |

## Verification
The bench sweeps every combination of the three external triggers on each thread in turn. It checks the cause vector after each switch. A design that ORed the causes wrongly or latched them late would report a wrong or empty vector. The same combinations are also raised on the idle thread, where a design that did not qualify events by owner would switch. Triggers injected in the middle of the dead period would show up in a faulty design as a lengthened penalty, a double switch or a corrupted cause. The bench also checks the exact 8/7 split of flush and the return of issue with the flipped ID. A sweep of small timeout limits catches off-by-one errors in the fairness counter, and also a counter that fails to restart when ownership changes.

// File: rtl/soe_pkg.sv
package soe_pkg;
  localparam int CAUSE_W   = 4;
  localparam int C_MISS    = 0;
  localparam int C_INVAL   = 1;
  localparam int C_TMO     = 2;
  localparam int C_HINT    = 3;
  localparam int THREADS   = 2;

  typedef enum logic {
    ST_RUN    = 1'b0,
    ST_SWITCH = 1'b1
  } seq_state_e;
endpackage

// File: rtl/soe_trigger.sv
module soe_trigger
  import soe_pkg::*;
(
  input  logic               tid,
  input  logic               run,
  input  logic [THREADS-1:0] ev_miss,
  input  logic [THREADS-1:0] ev_inval,
  input  logic [THREADS-1:0] ev_hint,
  input  logic               tmo_expire,
  output logic [CAUSE_W-1:0] cause_now,
  output logic               fire
);
  always_comb begin
    cause_now = '0;
    if (run) begin
      cause_now[C_MISS]  = ev_miss[tid];
      cause_now[C_INVAL] = ev_inval[tid];
      cause_now[C_TMO]   = tmo_expire;
      cause_now[C_HINT]  = ev_hint[tid];
    end
    fire = |cause_now;
  end
endmodule

// File: rtl/soe_fair_timer.sv
module soe_fair_timer #(
  parameter int TMO_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             gain,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    expire = run && (cnt_q >= limit);
    cnt_en = gain || (run && !expire);
    cnt_d  = gain ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/soe_switch_seq.sv
module soe_switch_seq
  import soe_pkg::*;
#(
  parameter int FLUSH_CYCLES = 8,
  parameter int DELAY_CYCLES = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic run,
  output logic flush,
  output logic gain,
  output logic tid
);
  localparam int PEN = FLUSH_CYCLES + DELAY_CYCLES;
  localparam int CW  = (PEN > 1) ? $clog2(PEN) : 1;
  localparam logic [CW-1:0] LAST  = CW'(PEN - 1);
  localparam logic [CW-1:0] DLY_C = CW'(DELAY_CYCLES);

  seq_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic tid_q, tid_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    tid_d = tid_q;
    gain  = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (fire) begin
          st_d  = ST_SWITCH;
          cnt_d = LAST;
        end
      end
      ST_SWITCH: begin
        if (cnt_q == '0) begin
          st_d  = ST_RUN;
          tid_d = ~tid_q;
          gain  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      cnt_q <= '0;
      tid_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      tid_q <= tid_d;
    end
  end

  assign run   = (st_q == ST_RUN);
  assign flush = (st_q == ST_SWITCH) && (cnt_q >= DLY_C);
  assign tid   = tid_q;
endmodule

// File: rtl/soe_thread_ctrl.sv
module soe_thread_ctrl
  import soe_pkg::*;
#(
  parameter int FLUSH_CYCLES = 8,
  parameter int DELAY_CYCLES = 7,
  parameter int TMO_W        = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TMO_W-1:0]   tmo_limit,
  input  logic [THREADS-1:0] ev_miss,
  input  logic [THREADS-1:0] ev_inval,
  input  logic [THREADS-1:0] ev_hint,
  output logic               active_tid,
  output logic               issue_en,
  output logic               flush,
  output logic [THREADS-1:0] thr_sel,
  output logic [CAUSE_W-1:0] cause
);
  logic run, gain, fire, tmo_expire, tid;
  logic [CAUSE_W-1:0] cause_now, cause_q;

  soe_fair_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .gain(gain),
    .limit(tmo_limit), .expire(tmo_expire)
  );

  soe_trigger u_trig (
    .tid(tid), .run(run), .ev_miss(ev_miss), .ev_inval(ev_inval),
    .ev_hint(ev_hint), .tmo_expire(tmo_expire),
    .cause_now(cause_now), .fire(fire)
  );

  soe_switch_seq #(
    .FLUSH_CYCLES(FLUSH_CYCLES), .DELAY_CYCLES(DELAY_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .fire(fire), .run(run),
    .flush(flush), .gain(gain), .tid(tid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cause_q <= '0;
    else if (fire) cause_q <= cause_now;
  end

  genvar gi;
  generate
    for (gi = 0; gi < THREADS; gi++) begin : g_sel
      assign thr_sel[gi] = (tid == gi[0]);
    end
  endgenerate

  assign active_tid = tid;
  assign issue_en   = run;
  assign cause      = cause_q;
endmodule

// File: rtl/soe_thread_ctrl_chk.sv
module soe_thread_ctrl_chk #(
  parameter int PENALTY = 15,
  parameter int FLUSH_N = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ev_miss,
  input logic [1:0] ev_inval,
  input logic [1:0] ev_hint,
  input logic       active_tid,
  input logic       issue_en,
  input logic       flush,
  input logic [1:0] thr_sel,
  input logic [3:0] cause
);
  logic [7:0] off_q;
  logic       ext_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         off_q <= '0;
    else if (!issue_en) off_q <= off_q + 1'b1;
    else                off_q <= '0;
  end

  assign ext_ev = ev_miss[active_tid] | ev_inval[active_tid] | ev_hint[active_tid];

  a_r2_event_starts_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_en && ext_ev) |=> (flush && !issue_en));

  a_r3_dead_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(issue_en) |-> (off_q == 8'(PENALTY)));

  a_r3_tid_flips: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(issue_en) |-> (active_tid != $past(active_tid)));

  a_r4_flush_blocks_issue: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !issue_en);

  a_r4_flush_first_part: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_en && off_q < 8'(FLUSH_N)) |-> flush);

  a_r5_cause_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_en && !$past(issue_en)) |-> $stable(cause));

  a_r8_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(issue_en) |-> (cause != 4'd0));

  a_r9_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(thr_sel) && thr_sel[active_tid]);
endmodule

bind soe_thread_ctrl soe_thread_ctrl_chk #(
  .PENALTY(FLUSH_CYCLES + DELAY_CYCLES), .FLUSH_N(FLUSH_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_miss(ev_miss), .ev_inval(ev_inval),
  .ev_hint(ev_hint), .active_tid(active_tid), .issue_en(issue_en),
  .flush(flush), .thr_sel(thr_sel), .cause(cause)
);

// File: tb/tb_soe_thread_ctrl.sv
module tb_soe_thread_ctrl;
  localparam int CLK_P  = 10;
  localparam int FLUSHN = 8;
  localparam int DELAYN = 7;
  localparam int PEN    = FLUSHN + DELAYN;
  localparam int TW     = 12;

  logic          clk;
  logic          rst_n;
  logic [TW-1:0] tmo_limit;
  logic [1:0]    ev_miss, ev_inval, ev_hint;
  logic          active_tid, issue_en, flush;
  logic [1:0]    thr_sel;
  logic [3:0]    cause;

  int checks = 0;
  int errors = 0;

  soe_thread_ctrl #(.FLUSH_CYCLES(FLUSHN), .DELAY_CYCLES(DELAYN), .TMO_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit), .ev_miss(ev_miss),
    .ev_inval(ev_inval), .ev_hint(ev_hint), .active_tid(active_tid),
    .issue_en(issue_en), .flush(flush), .thr_sel(thr_sel), .cause(cause)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input int lim);
    @(negedge clk);
    rst_n = 1'b0;
    tmo_limit = TW'(lim);
    ev_miss = '0; ev_inval = '0; ev_hint = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // ev bits: [0] miss, [1] invalidation, [2] hint
  task automatic raise(input int src, input logic [2:0] ev);
    ev_miss[src]  = ev[0];
    ev_inval[src] = ev[1];
    ev_hint[src]  = ev[2];
  endtask

  task automatic idle_event(input logic [2:0] ev);
    logic old_tid;
    @(negedge clk);
    old_tid = active_tid;
    raise(int'(~old_tid), ev);
    @(negedge clk);
    ev_miss = '0; ev_inval = '0; ev_hint = '0;
    for (int k = 0; k < 3; k++) begin
      chk(issue_en == 1'b1, "R6 issue kept", int'(issue_en), 1);
      chk(active_tid == old_tid, "R6 tid kept", int'(active_tid), int'(old_tid));
      @(negedge clk);
    end
  endtask

  task automatic active_event(input logic [2:0] ev);
    logic       old_tid;
    logic [3:0] exp_c;
    @(negedge clk);
    old_tid = active_tid;
    exp_c = {ev[2], 1'b0, ev[1], ev[0]};
    raise(int'(old_tid), ev);
    @(negedge clk);
    ev_miss = '0; ev_inval = '0; ev_hint = '0;
    chk(issue_en == 1'b0, "R2 issue off", int'(issue_en), 0);
    chk(flush == 1'b1, "R2 flush on", int'(flush), 1);
    chk(cause == exp_c, "R8 cause", int'(cause), int'(exp_c));
    for (int k = 0; k < PEN; k++) begin
      if (k > 0) @(negedge clk);
      chk(issue_en == 1'b0, "R3 dead period", int'(issue_en), 0);
      chk(flush == (k < FLUSHN), "R4 flush phase", int'(flush), int'(k < FLUSHN));
      if (k == 3) begin
        ev_miss = 2'b11; ev_hint = 2'b11; ev_inval = 2'b11;
      end else begin
        ev_miss = '0; ev_hint = '0; ev_inval = '0;
      end
    end
    @(negedge clk);
    chk(issue_en == 1'b1, "R3 issue back", int'(issue_en), 1);
    chk(active_tid == ~old_tid, "R3 tid flip", int'(active_tid), int'(~old_tid));
    chk(thr_sel == (active_tid ? 2'b10 : 2'b01), "R9 sel", int'(thr_sel),
        active_tid ? 2 : 1);
    chk(cause == exp_c, "R5 cause unchanged", int'(cause), int'(exp_c));
    @(negedge clk);
    chk(issue_en == 1'b1, "R5 no second switch", int'(issue_en), 1);
  endtask

  task automatic count_run(input int lim, input logic exp_tid);
    int n = 0;
    chk(active_tid == exp_tid, "R7 owner", int'(active_tid), int'(exp_tid));
    while (issue_en && n < 5000) begin
      n++;
      @(negedge clk);
    end
    chk(n == lim + 1, "R7 run length", n, lim + 1);
    chk(cause == 4'b0100, "R7 timeout cause", int'(cause), 4);
    while (!issue_en) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tmo_limit = '0;
    ev_miss = '0; ev_inval = '0; ev_hint = '0;
    do_reset(4000);
    chk(active_tid == 1'b0, "R1 tid", int'(active_tid), 0);
    chk(issue_en == 1'b1, "R1 issue", int'(issue_en), 1);
    chk(flush == 1'b0, "R1 flush", int'(flush), 0);
    chk(cause == 4'd0, "R1 cause", int'(cause), 0);
    chk(thr_sel == 2'b01, "R1 sel", int'(thr_sel), 1);

    for (int rep = 0; rep < 2; rep++) begin
      for (int e = 1; e < 8; e++) begin
        idle_event(3'(e));
        active_event(3'(e));
      end
    end

    for (int lim = 0; lim < 6; lim++) begin
      do_reset(lim);
      count_run(lim, 1'b0);
      count_run(lim, 1'b1);
      count_run(lim, 1'b0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule